// File: doc/BRIEF.md
# Lockstep XOR Bus Scrambler

This block sits between a host-side port and a core-side port and XORs every word crossing it with a mask. The mask changes over time. A twin instance on a partner device applies the same mask in the same cycle. A word scrambled by one instance and unscrambled by the other therefore arrives in clear. A copy of either side that lacks its partner, or that holds another key, passes only garbage.

The mask comes from a 64-bit maximal-length LFSR. The LFSR is seeded from a per-board 64-bit ID, which is shifted in serially once after configuration. The LFSR advances once for each transfer strobe, whichever way the transfer goes. A resync input lets both ends restart from the seed together. A fixed mode uses the ID bits directly as a static mask. A few control lines are scrambled with further mask bits in the same way.

Top module: `xor_lockstep_scrambler`

## Requirements
- R1: After reset, key_valid is 0 and core_data_out, host_data_out and ctrl_out are all 0.
- R2: Each cycle with id_bit_valid high shifts id_bit into a 64-bit key, most significant bit first, so the first bit ends in key bit 63. key_valid rises at the clock edge that takes the 64th bit. Later id_bit_valid pulses leave the key and the outputs unchanged.
- R3: While key_valid is 0, all data and control outputs are 0, and xfer_strobe does not move the sequence.
- R4: When the key completes, the LFSR state is loaded with the key. An all-zero key loads 64'hA5A5_5A5A_C3C3_3C3C instead, so the state is never zero once key_valid is 1.
- R5: With key_valid 1, mask_mode 0 and resync 0, each clock edge with xfer_strobe high changes the state s to {s[62:0], s[63]^s[62]^s[60]^s[59]}. The new mask applies from the cycle after the strobe. Without a strobe the state holds.
- R6: With dir 0, core_data_out = host_data_in ^ mask[DATA_W-1:0] and host_data_out = 0. With dir 1, host_data_out = core_data_in ^ mask[DATA_W-1:0] and core_data_out = 0. The mask is state[DATA_W+CTRL_W-1:0].
- R7: ctrl_out = ctrl_in ^ mask[DATA_W +: CTRL_W] in either direction while key_valid is 1.
- R8: With mask_mode 1, the mask is key[DATA_W+CTRL_W-1:0], and strobes leave the LFSR state unchanged.
- R9: resync high with key_valid 1 reloads the seed of R4 at the next edge. It takes priority over a strobe in the same cycle.
- R10: Two instances loaded with the same key and given the same strobes undo each other's masking on data and control lines. An instance with another key returns the word XORed with the difference of the two masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_bit_valid | input | 1 | Qualifies id_bit |
| id_bit | input | 1 | Serial ID bit, MSB first |
| mask_mode | input | 1 | 0 rolling LFSR mask, 1 fixed ID mask |
| resync | input | 1 | Reload the seed |
| dir | input | 1 | 0 host to core, 1 core to host |
| xfer_strobe | input | 1 | One completed transfer, advances sequence |
| host_data_in | input | DATA_W | Word from host side |
| core_data_out | output | DATA_W | Scrambled word to core side |
| core_data_in | input | DATA_W | Word from core side |
| host_data_out | output | DATA_W | Scrambled word to host side |
| ctrl_in | input | CTRL_W | Control lines in |
| ctrl_out | output | CTRL_W | Scrambled control lines |
| key_valid | output | 1 | All 64 ID bits loaded |

## Verification
The data and control outputs are combinational from the mask register. They are checked one time unit after the inputs change, in the same cycle. A strobe, resync or 64th ID bit changes the mask only at the following edge, so the bench applies its model update after checking the current cycle and before the next falling-edge sample. key_valid is likewise expected exactly one edge after the last ID bit. The round trip through a partner instance and the garbage from a wrongly keyed instance are checked in the same cycle as the masked word.

// File: rtl/xls_pkg.sv
package xls_pkg;
    localparam int unsigned STATE_W = 64;
    localparam logic [STATE_W-1:0] ZERO_SEED_SUB = 64'hA5A5_5A5A_C3C3_3C3C;

    // Maximal-length feedback, taps at bits 63, 62, 60, 59
    function automatic logic [STATE_W-1:0] lfsr_step(input logic [STATE_W-1:0] s);
        return {s[STATE_W-2:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
    endfunction

    function automatic logic [STATE_W-1:0] seed_of(input logic [STATE_W-1:0] k);
        return (k == '0) ? ZERO_SEED_SUB : k;
    endfunction
endpackage

// File: rtl/xls_id_loader.sv
module xls_id_loader
    import xls_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_valid,
    input  logic               bit_in,
    output logic [STATE_W-1:0] key_q_o,
    output logic [STATE_W-1:0] key_next_o,
    output logic               valid_o,
    output logic               done_o
);
    localparam int unsigned CNT_W = $clog2(STATE_W + 1);

    typedef struct packed {
        logic [STATE_W-1:0] key;
        logic [CNT_W-1:0]   cnt;
        logic               valid;
    } ld_t;

    ld_t ld_q, ld_d;

    always_comb begin
        ld_d   = ld_q;
        done_o = 1'b0;
        if (bit_valid && !ld_q.valid) begin
            ld_d.key = {ld_q.key[STATE_W-2:0], bit_in};
            ld_d.cnt = ld_q.cnt + 1'b1;
            if (ld_q.cnt == CNT_W'(STATE_W - 1)) begin
                ld_d.valid = 1'b1;
                done_o     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ld_q <= '0;
        else        ld_q <= ld_d;
    end

    assign key_q_o    = ld_q.key;
    assign key_next_o = ld_d.key;
    assign valid_o    = ld_q.valid;
endmodule

// File: rtl/xls_mask_gen.sv
module xls_mask_gen
    import xls_pkg::*;
#(
    parameter int unsigned MASK_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seed_load,
    input  logic [STATE_W-1:0] seed_key,
    input  logic [STATE_W-1:0] key_q,
    input  logic               key_valid,
    input  logic               resync,
    input  logic               strobe,
    input  logic               fixed_mode,
    output logic [MASK_W-1:0]  mask_o,
    output logic [STATE_W-1:0] state_o
);
    typedef struct packed {
        logic [STATE_W-1:0] state;
    } mg_t;

    mg_t mg_q, mg_d;

    always_comb begin
        mg_d = mg_q;
        if (seed_load)
            mg_d.state = seed_of(seed_key);
        else if (key_valid && resync)
            mg_d.state = seed_of(key_q);
        else if (key_valid && strobe && !fixed_mode)
            mg_d.state = lfsr_step(mg_q.state);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mg_q <= '0;
        else        mg_q <= mg_d;
    end

    assign mask_o  = fixed_mode ? key_q[MASK_W-1:0] : mg_q.state[MASK_W-1:0];
    assign state_o = mg_q.state;
endmodule

// File: rtl/xls_xor_path.sv
module xls_xor_path #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CTRL_W = 4,
    localparam int unsigned MASK_W = DATA_W + CTRL_W
) (
    input  logic              enable,
    input  logic              dir,
    input  logic [MASK_W-1:0] mask,
    input  logic [DATA_W-1:0] host_in,
    input  logic [DATA_W-1:0] core_in,
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic [DATA_W-1:0] core_out,
    output logic [DATA_W-1:0] host_out,
    output logic [CTRL_W-1:0] ctrl_out
);
    logic [DATA_W-1:0] dmask;
    logic [CTRL_W-1:0] cmask;

    assign dmask = mask[DATA_W-1:0];
    assign cmask = mask[DATA_W +: CTRL_W];

    always_comb begin
        core_out = '0;
        host_out = '0;
        ctrl_out = '0;
        if (enable) begin
            if (dir) host_out = core_in ^ dmask;
            else     core_out = host_in ^ dmask;
            ctrl_out = ctrl_in ^ cmask;
        end
    end
endmodule

// File: rtl/xor_lockstep_scrambler.sv
module xor_lockstep_scrambler
    import xls_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_bit_valid,
    input  logic              id_bit,
    input  logic              mask_mode,
    input  logic              resync,
    input  logic              dir,
    input  logic              xfer_strobe,
    input  logic [DATA_W-1:0] host_data_in,
    output logic [DATA_W-1:0] core_data_out,
    input  logic [DATA_W-1:0] core_data_in,
    output logic [DATA_W-1:0] host_data_out,
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic [CTRL_W-1:0] ctrl_out,
    output logic              key_valid
);
    localparam int unsigned MASK_W = DATA_W + CTRL_W;

    logic [STATE_W-1:0] key_q, key_next, lfsr_state;
    logic               load_done;
    logic [MASK_W-1:0]  mask;

    xls_id_loader u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (id_bit_valid),
        .bit_in     (id_bit),
        .key_q_o    (key_q),
        .key_next_o (key_next),
        .valid_o    (key_valid),
        .done_o     (load_done)
    );

    xls_mask_gen #(.MASK_W(MASK_W)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_load  (load_done),
        .seed_key   (key_next),
        .key_q      (key_q),
        .key_valid  (key_valid),
        .resync     (resync),
        .strobe     (xfer_strobe),
        .fixed_mode (mask_mode),
        .mask_o     (mask),
        .state_o    (lfsr_state)
    );

    xls_xor_path #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_path (
        .enable   (key_valid),
        .dir      (dir),
        .mask     (mask),
        .host_in  (host_data_in),
        .core_in  (core_data_in),
        .ctrl_in  (ctrl_in),
        .core_out (core_data_out),
        .host_out (host_data_out),
        .ctrl_out (ctrl_out)
    );
endmodule

// File: rtl/xls_checker.sv
module xls_checker #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CTRL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_valid,
    input logic              xfer_strobe,
    input logic              resync,
    input logic              mask_mode,
    input logic              dir,
    input logic [DATA_W-1:0] core_data_out,
    input logic [DATA_W-1:0] host_data_out,
    input logic [CTRL_W-1:0] ctrl_out,
    input logic [63:0]       lfsr_state
);
    a_r3_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> (core_data_out == '0 && host_data_out == '0 && ctrl_out == '0));

    a_r2_valid_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> key_valid);

    a_r4_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> lfsr_state != 64'd0);

    a_r5_strobe_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && xfer_strobe && !resync && !mask_mode) |=> !$stable(lfsr_state));

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && !xfer_strobe && !resync) |=> $stable(lfsr_state));

    a_r8_fixed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && mask_mode && !resync) |=> $stable(lfsr_state));

    a_r6_dir_host_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dir |-> host_data_out == '0);

    a_r6_dir_core_idle: assert property (@(posedge clk) disable iff (!rst_n)
        dir |-> core_data_out == '0);
endmodule

bind xor_lockstep_scrambler xls_checker #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .key_valid     (key_valid),
    .xfer_strobe   (xfer_strobe),
    .resync        (resync),
    .mask_mode     (mask_mode),
    .dir           (dir),
    .core_data_out (core_data_out),
    .host_data_out (host_data_out),
    .ctrl_out      (ctrl_out),
    .lfsr_state    (lfsr_state)
);

// File: tb/xor_lockstep_scrambler_tb.sv
module xor_lockstep_scrambler_tb;
    localparam int DW = 16;
    localparam int CW = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, id_valid, id_bit, rid_bit, mode, resync, dir, strobe;
    logic [DW-1:0] hin, cin;
    logic [CW-1:0] cti;
    logic [DW-1:0] core_o, host_o, p_core_o, p_host_o, r_core_o, r_host_o;
    logic [CW-1:0] ct_o, p_ct_o, r_ct_o;
    logic          kv, p_kv, r_kv;

    xor_lockstep_scrambler u_dut (
        .clk(clk), .rst_n(rst_n), .id_bit_valid(id_valid), .id_bit(id_bit),
        .mask_mode(mode), .resync(resync), .dir(dir), .xfer_strobe(strobe),
        .host_data_in(hin), .core_data_out(core_o), .core_data_in(cin),
        .host_data_out(host_o), .ctrl_in(cti), .ctrl_out(ct_o), .key_valid(kv));

    // Partner with the same key, receiving the scrambled word
    xor_lockstep_scrambler u_peer (
        .clk(clk), .rst_n(rst_n), .id_bit_valid(id_valid), .id_bit(id_bit),
        .mask_mode(mode), .resync(resync), .dir(1'b1), .xfer_strobe(strobe),
        .host_data_in('0), .core_data_out(p_core_o), .core_data_in(core_o),
        .host_data_out(p_host_o), .ctrl_in(ct_o), .ctrl_out(p_ct_o), .key_valid(p_kv));

    // Partner with a different key
    xor_lockstep_scrambler u_rogue (
        .clk(clk), .rst_n(rst_n), .id_bit_valid(id_valid), .id_bit(rid_bit),
        .mask_mode(mode), .resync(resync), .dir(1'b1), .xfer_strobe(strobe),
        .host_data_in('0), .core_data_out(r_core_o), .core_data_in(core_o),
        .host_data_out(r_host_o), .ctrl_in(ct_o), .ctrl_out(r_ct_o), .key_valid(r_kv));

    int checks = 0, fails = 0, garbage_seen = 0;
    logic [63:0] m_key, m_rkey, m_st, m_rst;
    logic        m_valid;
    logic [31:0] lcg = 32'h1234_5678;

    function automatic logic [63:0] nxt(input logic [63:0] s);
        return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
    endfunction
    function automatic logic [63:0] sd(input logic [63:0] k);
        return (k == 64'd0) ? 64'hA5A5_5A5A_C3C3_3C3C : k;
    endfunction
    function automatic logic [19:0] mk(input logic [63:0] s, input logic [63:0] k);
        return mode ? k[19:0] : s[19:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs();
        logic [19:0] ma, mr;
        logic [DW-1:0] ec, eh;
        logic [CW-1:0] et;
        ma = mk(m_st, m_key);
        mr = mk(m_rst, m_rkey);
        if (!m_valid) begin
            ec = '0; eh = '0; et = '0;
        end else begin
            ec = dir ? '0 : hin ^ ma[15:0];
            eh = dir ? cin ^ ma[15:0] : '0;
            et = cti ^ ma[19:16];
        end
        check(core_o == ec, "R6 core_data_out", 64'(core_o), 64'(ec));
        check(host_o == eh, "R6 host_data_out", 64'(host_o), 64'(eh));
        check(ct_o == et, "R7 ctrl_out", 64'(ct_o), 64'(et));
        if (m_valid && !dir) begin
            check(p_host_o == hin, "R10 peer round trip data", 64'(p_host_o), 64'(hin));
            check(p_ct_o == cti, "R10 peer round trip ctrl", 64'(p_ct_o), 64'(cti));
            check(r_host_o == (hin ^ ma[15:0] ^ mr[15:0]), "R10 rogue data",
                  64'(r_host_o), 64'(hin ^ ma[15:0] ^ mr[15:0]));
            if (ma[15:0] != mr[15:0]) begin
                garbage_seen++;
                check(r_host_o != hin, "R10 rogue garbage", 64'(r_host_o), 64'(hin));
            end
        end
    endtask

    // Check the current cycle, then advance the model across the next edge
    task automatic cycle(input bit do_check);
        #1;
        if (do_check) check_outs();
        if (m_valid) begin
            if (resync) begin
                m_st = sd(m_key); m_rst = sd(m_rkey);
            end else if (strobe && !mode) begin
                m_st = nxt(m_st); m_rst = nxt(m_rst);
            end
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; id_valid = 0; id_bit = 0; rid_bit = 0; mode = 0; resync = 0;
        dir = 0; strobe = 0; hin = '0; cin = '0; cti = '0;
        m_valid = 0; m_st = '0; m_rst = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_key(input logic [63:0] k, input logic [63:0] rk);
        m_key = k; m_rkey = rk;
        for (int i = 63; i >= 0; i--) begin
            id_valid = 1'b1; id_bit = k[i]; rid_bit = rk[i];
            if (i == 0) begin
                #1;
                check(kv == 1'b0, "R2 key_valid low before last bit", 64'(kv), 64'd0);
                strobe = 1'b1; hin = 16'hBEEF; cti = 4'hF;
                check_outs(); // R3: outputs quiet while loading
                strobe = 1'b0;
            end
            @(negedge clk);
        end
        id_valid = 1'b0;
        m_valid = 1'b1; m_st = sd(k); m_rst = sd(rk);
        #1;
        check(kv == 1'b1, "R2 key_valid after 64th bit", 64'(kv), 64'd1);
        @(negedge clk);
    endtask

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    initial begin
        do_reset();
        // R1 reset state
        #1;
        check(kv == 1'b0, "R1 key_valid", 64'(kv), 64'd0);
        check(core_o == '0 && host_o == '0 && ct_o == '0, "R1 outputs zero",
              {core_o, host_o, 28'(ct_o)}, 64'd0);
        @(negedge clk);
        // R3: strobes before key is loaded are ignored
        strobe = 1'b1; hin = 16'h1357; cti = 4'h5;
        repeat (4) cycle(1);
        strobe = 1'b0;

        load_key(64'h3C5A_9E17_B204_6DF1, ~64'h3C5A_9E17_B204_6DF1);
        // R4: mask equals the key bits right after load (MSB-first order, R2)
        dir = 0; hin = 16'h0000; cti = 4'h0;
        #1;
        check(core_o == 16'h6DF1, "R4 seed equals key", 64'(core_o), 64'h6DF1);
        check(ct_o == 4'h4, "R4 ctrl seed bits", 64'(ct_o), 64'h4);
        @(negedge clk);

        // R2: extra ID bits are ignored
        id_valid = 1'b1; id_bit = 1'b1; rid_bit = 1'b1;
        repeat (5) cycle(1);
        id_valid = 1'b0;
        cycle(1);

        // R5/R6/R7/R10 sweep
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = rnd();
            hin = r[15:0]; cin = r[31:16]; cti = r[19:16] ^ r[3:0];
            dir = r[21]; strobe = r[22] | r[23];
            cycle(1);
        end
        strobe = 0;
        check(garbage_seen > 0, "R10 rogue produced garbage", 64'(garbage_seen), 64'd1);

        // R9: resync with strobe reloads seed
        resync = 1'b1; strobe = 1'b1; cycle(1);
        resync = 1'b0; strobe = 1'b0; dir = 0; hin = '0;
        #1;
        check(core_o == 16'h6DF1, "R9 resync reloads seed", 64'(core_o), 64'h6DF1);
        @(negedge clk);

        // R8: fixed mode uses the key directly; strobes do not move it
        strobe = 1'b1; cycle(1); strobe = 1'b0; // advance once in rolling mode
        mode = 1'b1; hin = 16'hFFFF;
        #1;
        check(core_o == (16'hFFFF ^ 16'h6DF1), "R8 fixed mask from key",
              64'(core_o), 64'(16'hFFFF ^ 16'h6DF1));
        @(negedge clk);
        strobe = 1'b1;
        for (int n = 0; n < 20; n++) begin
            hin = 16'(rnd()); dir = n[0]; cycle(1);
        end
        strobe = 1'b0; mode = 1'b0;
        cycle(1); // R8: rolling mask resumes from the state held before
        for (int n = 0; n < 20; n++) begin
            hin = 16'(rnd()); strobe = n[1]; dir = 0; cycle(1);
        end
        strobe = 0;

        // R4: zero key substitutes the constant
        do_reset();
        load_key(64'd0, 64'h0000_0000_0000_0001);
        dir = 0; hin = '0; cti = '0;
        #1;
        check(core_o == 16'h3C3C, "R4 zero key fallback", 64'(core_o), 64'h3C3C);
        check(ct_o == 4'h3, "R4 zero key fallback ctrl", 64'(ct_o), 64'h3);
        @(negedge clk);
        for (int n = 0; n < 100; n++) begin
            logic [31:0] r;
            r = rnd();
            hin = r[15:0]; cin = r[31:16]; cti = r[27:24];
            dir = r[20]; strobe = r[25];
            cycle(1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule